// File: doc/BRIEF.md
# User-Level Trap State Unit

This unit keeps the state a hart needs to take a trap into a user-level handler and to come back from it. It holds five registers: a status word with a two-bit interrupt-enable stack, the exception PC, the cause, the trap value and a scratch word. A trap-entry strobe supplies the cause, an interrupt flag, the PC of the interrupted instruction, a faulting address and the raw instruction bits. The unit records them, pushes the enable stack and turns interrupts off. A return strobe pops the stack and presents the saved PC as the resume address.

Software reads and writes the registers through a single-cycle CSR port. The port selects a register with a 3-bit code. Reads are combinational. Writes take effect at the next clock edge. The enable stack has no previous-privilege field, because only user mode can be interrupted into a user-level handler. The current enable bit is exported so that interrupt arbitration can gate on it.

Top module: `utrap_csr`

## Requirements
- R1: After reset every register reads zero on the CSR port and `intr_en_o` is 0.
- R2: At a clock edge with `trap_i` high, the previous-enable bit (status bit 4) takes the old enable bit (status bit 0), and the enable bit is cleared.
- R3: At a clock edge with `ret_i` high and `trap_i` low, the enable bit takes the previous-enable bit and the previous-enable bit is set. While `ret_i` is high, `resume_vld_o` is 1 and `resume_pc_o` equals the saved exception PC.
- R4: At trap entry the exception PC captures `trap_pc_i` with bit 0 forced to zero. Bit 1 is also forced to zero when `HALF_ALIGN` is 0. Software writes obey the same mask.
- R5: At trap entry the cause register (select 3) holds the interrupt flag in bit XLEN-1 and the code in bits CW-1:0. Every other bit reads zero, and software writes are limited to those same bits.
- R6: For an exception (interrupt flag 0) with code 0, 1, 3, 4, 5, 6, 7, 12, 13 or 15, the trap value register captures `trap_addr_i`.
- R7: For an exception with code 2 (illegal instruction), the trap value register captures `trap_insn_i`.
- R8: For every interrupt, and for every other exception code, the trap value register is written with zero.
- R9: Software writes reach the registers at these selects: 0 status, 1 scratch, 2 exception PC, 3 cause, 4 trap value. The status register stores only bits 0 and 4. Scratch and trap value store all bits.
- R10: When a trap entry and a CSR write to any trap register fall in the same cycle, the trap entry values are kept and the write is lost. Trap entry also wins over a same-cycle return.
- R11: Selects 5 to 7 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Trap entry strobe |
| trap_intr_i | input | 1 | Trap is an interrupt |
| trap_code_i | input | CW | Interrupt or exception code |
| trap_pc_i | input | XLEN | PC of the interrupted or faulting instruction |
| trap_addr_i | input | XLEN | Faulting virtual address |
| trap_insn_i | input | XLEN | Bits of the faulting instruction |
| ret_i | input | 1 | Return instruction strobe |
| resume_pc_o | output | XLEN | PC to resume at |
| resume_vld_o | output | 1 | Resume PC is valid this cycle |
| intr_en_o | output | 1 | Current user interrupt enable |
| csr_we_i | input | 1 | CSR write enable |
| csr_sel_i | input | 3 | CSR register select |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data |

## Verification
Every register update from a trap, a return or a CSR write lands at the first rising edge after the strobe. The read port has no register stage, so a result can be read half a cycle after that edge. The resume PC and its valid flag are combinational and are checked in the same cycle `ret_i` is high, before the edge. The bench drives all stimulus at the falling edge and reads one falling edge later, after exactly one rising edge has passed. It sweeps every code from 0 to 15 in both interrupt and exception form, with the enable bit alternating.

// File: rtl/utrap_csr.sv
module utrap_csr #(
  parameter int XLEN       = 32,
  parameter int CW         = 6,
  parameter bit HALF_ALIGN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_i,
  input  logic            trap_intr_i,
  input  logic [CW-1:0]   trap_code_i,
  input  logic [XLEN-1:0] trap_pc_i,
  input  logic [XLEN-1:0] trap_addr_i,
  input  logic [XLEN-1:0] trap_insn_i,
  input  logic            ret_i,
  output logic [XLEN-1:0] resume_pc_o,
  output logic            resume_vld_o,
  output logic            intr_en_o,
  input  logic            csr_we_i,
  input  logic [2:0]      csr_sel_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o
);
  localparam logic [2:0] SEL_STAT = 3'd0;
  localparam logic [2:0] SEL_SCR  = 3'd1;
  localparam logic [2:0] SEL_EPC  = 3'd2;
  localparam logic [2:0] SEL_CAU  = 3'd3;
  localparam logic [2:0] SEL_TVAL = 3'd4;
  localparam logic [XLEN-1:0] EPC_MASK = {{(XLEN-2){1'b1}}, HALF_ALIGN, 1'b0};

  logic            ie_q, pie_q, cint_q;
  logic [CW-1:0]   ccode_q;
  logic [XLEN-1:0] scr_q, epc_q, tval_q, tval_d;

  wire wr_stat = csr_we_i && (csr_sel_i == SEL_STAT);
  wire wr_scr  = csr_we_i && (csr_sel_i == SEL_SCR);
  wire wr_epc  = csr_we_i && (csr_sel_i == SEL_EPC);
  wire wr_cau  = csr_we_i && (csr_sel_i == SEL_CAU);
  wire wr_tval = csr_we_i && (csr_sel_i == SEL_TVAL);

  always_comb begin
    tval_d = '0;
    if (!trap_intr_i) begin
      case (trap_code_i)
        CW'(0), CW'(1), CW'(3), CW'(4), CW'(5), CW'(6), CW'(7),
        CW'(12), CW'(13), CW'(15): tval_d = trap_addr_i;
        CW'(2):                    tval_d = trap_insn_i;
        default:                   tval_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      pie_q <= 1'b0;
    end else if (trap_i) begin
      pie_q <= ie_q;
      ie_q  <= 1'b0;
    end else if (ret_i) begin
      ie_q  <= pie_q;
      pie_q <= 1'b1;
    end else if (wr_stat) begin
      ie_q  <= csr_wdata_i[0];
      pie_q <= csr_wdata_i[4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cint_q  <= 1'b0;
      ccode_q <= '0;
      tval_q  <= '0;
      scr_q   <= '0;
    end else begin
      if (trap_i)      epc_q <= trap_pc_i & EPC_MASK;
      else if (wr_epc) epc_q <= csr_wdata_i & EPC_MASK;

      if (trap_i) begin
        cint_q  <= trap_intr_i;
        ccode_q <= trap_code_i;
      end else if (wr_cau) begin
        cint_q  <= csr_wdata_i[XLEN-1];
        ccode_q <= csr_wdata_i[CW-1:0];
      end

      if (trap_i)       tval_q <= tval_d;
      else if (wr_tval) tval_q <= csr_wdata_i;

      if (wr_scr) scr_q <= csr_wdata_i;
    end
  end

  always_comb begin
    case (csr_sel_i)
      SEL_STAT: csr_rdata_o = XLEN'({pie_q, 3'b000, ie_q});
      SEL_SCR:  csr_rdata_o = scr_q;
      SEL_EPC:  csr_rdata_o = epc_q;
      SEL_CAU:  csr_rdata_o = {cint_q, {(XLEN-1-CW){1'b0}}, ccode_q};
      SEL_TVAL: csr_rdata_o = tval_q;
      default:  csr_rdata_o = '0;
    endcase
  end

  assign resume_pc_o  = epc_q;
  assign resume_vld_o = ret_i;
  assign intr_en_o    = ie_q;
endmodule

module utrap_csr_chk #(
  parameter int XLEN       = 32,
  parameter bit HALF_ALIGN = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_i,
  input logic            ret_i,
  input logic [XLEN-1:0] trap_pc_i,
  input logic            ie_q,
  input logic            pie_q,
  input logic [XLEN-1:0] epc_q
);
  // R2
  trap_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> !ie_q);
  // R2
  trap_pushes_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> pie_q == $past(ie_q));
  // R3
  ret_pops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !trap_i) |=> (ie_q == $past(pie_q)) && pie_q);
  // R4
  epc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !epc_q[0] && (HALF_ALIGN || !epc_q[1]));
  // R10
  trap_epc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> epc_q[XLEN-1:2] == $past(trap_pc_i[XLEN-1:2]));
endmodule

bind utrap_csr utrap_csr_chk #(.XLEN(XLEN), .HALF_ALIGN(HALF_ALIGN)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .ret_i(ret_i),
  .trap_pc_i(trap_pc_i), .ie_q(ie_q), .pie_q(pie_q), .epc_q(epc_q));

// File: tb/test_utrap_csr.sv
module test_utrap_csr;
  localparam int CLK_P = 10;
  localparam int XLEN  = 32;
  localparam int CW    = 6;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic            trap_i = 0, trap_intr_i = 0, ret_i = 0, csr_we_i = 0;
  logic [CW-1:0]   trap_code_i = '0;
  logic [XLEN-1:0] trap_pc_i = '0, trap_addr_i = '0, trap_insn_i = '0, csr_wdata_i = '0;
  logic [2:0]      csr_sel_i = '0;
  logic [XLEN-1:0] resume_pc_o, csr_rdata_o;
  logic            resume_vld_o, intr_en_o;
  int errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  utrap_csr #(.XLEN(XLEN), .CW(CW), .HALF_ALIGN(1'b1)) i_utrap_csr (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .trap_intr_i(trap_intr_i),
    .trap_code_i(trap_code_i), .trap_pc_i(trap_pc_i), .trap_addr_i(trap_addr_i),
    .trap_insn_i(trap_insn_i), .ret_i(ret_i), .resume_pc_o(resume_pc_o),
    .resume_vld_o(resume_vld_o), .intr_en_o(intr_en_o), .csr_we_i(csr_we_i),
    .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o));

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] sel, output logic [XLEN-1:0] v);
    csr_sel_i = sel;
    #1 v = csr_rdata_o;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [XLEN-1:0] d);
    @(negedge clk);
    csr_we_i = 1; csr_sel_i = sel; csr_wdata_i = d;
    @(negedge clk);
    csr_we_i = 0;
  endtask

  task automatic trap(input logic intr, input logic [CW-1:0] code,
                      input logic [XLEN-1:0] pc, input logic [XLEN-1:0] ad, input logic [XLEN-1:0] ins);
    @(negedge clk);
    trap_i = 1; trap_intr_i = intr; trap_code_i = code;
    trap_pc_i = pc; trap_addr_i = ad; trap_insn_i = ins;
    @(negedge clk);
    trap_i = 0;
  endtask

  function automatic logic [XLEN-1:0] exp_tval(input logic intr, input int code,
                                               input logic [XLEN-1:0] ad, input logic [XLEN-1:0] ins);
    if (intr) return '0;
    if (code == 2) return ins;
    if (code < 16 && code != 8 && code != 9 && code != 10 && code != 11 && code != 14) return ad;
    return '0;
  endfunction

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] v, pc, ad, ins;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 5; s++) begin rd(3'(s), v); check("R1", v, '0); end
    check("R1 ie", XLEN'(intr_en_o), '0);

    // R9 status stores bits 0 and 4 only
    wr(3'd0, '1); rd(3'd0, v); check("R9 status", v, 32'h11);
    check("R9 ie", XLEN'(intr_en_o), 1);

    // R2..R8 sweep: every code, both kinds, enable alternating
    for (int intr = 0; intr < 2; intr++) begin
      for (int code = 0; code < 16; code++) begin
        pc  = 32'h8000_1003 + 32'(code * 32'h1110) + 32'(intr << 20);
        ad  = 32'hA000_0000 ^ 32'(code * 7 + intr);
        ins = 32'h0000_0013 | 32'(code << 12);
        wr(3'd0, 32'(code & 1));
        trap(intr[0], CW'(code), pc, ad, ins);
        rd(3'd0, v); check("R2 status after trap", v, 32'((code & 1) << 4));
        check("R2 ie", XLEN'(intr_en_o), '0);
        rd(3'd3, v); check("R5 cause", v, {intr[0], 31'(code)});
        rd(3'd2, v); check("R4 epc", v, pc & 32'hFFFF_FFFE);
        rd(3'd4, v);
        check(intr ? "R8 tval" : (code == 2 ? "R7 tval" : "R6/R8 tval"),
              v, exp_tval(intr[0], code, ad, ins));
        @(negedge clk);
        ret_i = 1;
        #1 check("R3 resume pc", resume_pc_o, pc & 32'hFFFF_FFFE);
        check("R3 resume vld", XLEN'(resume_vld_o), 1);
        @(negedge clk);
        ret_i = 0;
        rd(3'd0, v); check("R3 status after ret", v, 32'h10 | 32'(code & 1));
      end
    end

    // R8 exception code above 15
    trap(1'b0, CW'(20), 32'h100, 32'h1234, 32'h5678);
    rd(3'd4, v); check("R8 tval code20", v, '0);

    // R9 other registers
    wr(3'd1, 32'hDEAD_BEEF); rd(3'd1, v); check("R9 scratch", v, 32'hDEAD_BEEF);
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, v); check("R9 tval", v, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); check("R4 epc write", v, 32'hFFFF_FFFE);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); check("R5 cause write", v, 32'h8000_003F);

    // R11 unused selects
    for (int s = 5; s < 8; s++) begin
      wr(3'(s), 32'h5555_5555);
      rd(3'(s), v); check("R11 read", v, '0);
    end
    rd(3'd1, v); check("R11 scratch kept", v, 32'hDEAD_BEEF);
    rd(3'd2, v); check("R11 epc kept", v, 32'hFFFF_FFFE);
    rd(3'd0, v); check("R11 status kept", v, 32'h10);

    // R10 trap vs same-cycle CSR write / return
    @(negedge clk);
    csr_we_i = 1; csr_sel_i = 3'd2; csr_wdata_i = 32'h0000_4444;
    trap_i = 1; trap_intr_i = 0; trap_code_i = CW'(5);
    trap_pc_i = 32'h0000_9000; trap_addr_i = 32'h77; trap_insn_i = '0;
    @(negedge clk);
    csr_we_i = 0; trap_i = 0;
    rd(3'd2, v); check("R10 epc", v, 32'h0000_9000);
    wr(3'd0, 32'h1);
    @(negedge clk);
    csr_we_i = 1; csr_sel_i = 3'd0; csr_wdata_i = 32'h11;
    trap_i = 1; ret_i = 1; trap_intr_i = 1; trap_code_i = CW'(4); trap_pc_i = 32'h40;
    @(negedge clk);
    csr_we_i = 0; trap_i = 0; ret_i = 0;
    rd(3'd0, v); check("R10 status", v, 32'h10);
    rd(3'd4, v); check("R10 tval", v, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule